// File: doc/BRIEF.md
# Dueling Fault Isolation Controller

This block narrows a single faulty logic resource down to one position by letting pairs of configurations run side by side. The configuration population is split into two equal pools, a left pool and a right pool. Each duel takes one member from each pool, and the two members are meant to occupy disjoint resources. An external comparator reports whether their outputs agreed. The block keeps a suspect set as a bitmask over all resources. Each duel outcome shrinks that set by intersecting it with, or removing from it, the resources used by the two duelists.

Each configuration's resource footprint is a bitmask loaded through a write port. Every configuration also carries a saturating fitness score. Agreement raises the score and disagreement lowers it, so candidates that keep failing stop being chosen. A mode input tells the block whether the workload exposes a fault on every comparison or only on some of them. In the first case a clean comparison clears the duelists' resources. In the second case only disagreements carry information.

Top module: `duel_isolator`

## Requirements
- R1: After reset the suspect set holds all ones, every fitness score equals FIT_INIT (128 by default), no pair is selected, and the located and error flags are low.
- R2: A write with cfg_we_i high stores cfg_wmask_i as the resource mask of configuration cfg_waddr_i, and a later write to the same index replaces it.
- R3: A start_i pulse while no duel is open selects, one cycle later, the fittest configuration of the left pool (indices 0 to NUM_CFG/2-1) and the fittest of the right pool (NUM_CFG/2 to NUM_CFG-1). Ties go to the lowest index, and the pair is held until the duel ends.
- R4: A result strobe (res_valid_i) during an open duel closes it on the next cycle. A result strobe while no duel is open changes neither the suspect set nor any fitness score.
- R5: A discrepancy (res_match_i low) replaces the suspect set with its AND with the union of the two duelists' masks.
- R6: In always-articulating mode (mode_i = 0), a match removes the union of the two duelists' masks from the suspect set.
- R7: In sometimes-articulating mode (mode_i = 1), a match leaves the suspect set unchanged.
- R8: If an update would leave the suspect set empty, the set keeps its old value and error_o rises and stays high until reset.
- R9: located_o is high when at least one discrepancy has been applied and exactly one suspect bit remains. fault_idx_o gives the position of the lowest set suspect bit.
- R10: Fitness is an 8-bit counter per configuration. A match raises both duelists' scores by one, saturating at 255. A discrepancy lowers both by one, saturating at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Resource mask write enable |
| cfg_waddr_i | input | CFG_W | Configuration index to write |
| cfg_wmask_i | input | NUM_RES | Resource mask to store |
| start_i | input | 1 | Open a duel |
| mode_i | input | 1 | 0: always articulating, 1: sometimes articulating |
| res_valid_i | input | 1 | Comparator result strobe |
| res_match_i | input | 1 | Comparator outputs agreed |
| pair_valid_o | output | 1 | Duel open, pair outputs valid |
| left_sel_o | output | CFG_W | Selected left-pool configuration |
| right_sel_o | output | CFG_W | Selected right-pool configuration |
| suspect_o | output | NUM_RES | Current suspect set |
| located_o | output | 1 | Fault isolated to one resource |
| fault_idx_o | output | RES_W | Index of lowest suspect bit |
| error_o | output | 1 | Inconsistent outcomes seen (sticky) |
| fitness_o | output | NUM_CFG*FIT_W | Fitness scores, configuration i at bits i*FIT_W |

## Verification
The assertions check the following on every cycle:
- Each selection lies in its own pool and stays stable while a duel is open.
- A result closes the duel.
- Idle strobes do nothing.
- A discrepancy never adds suspects.
- A match in sometimes-articulating mode freezes the set.
- The set is never empty.
- The error flag is sticky.
- The located flag implies a single suspect bit that agrees with the index output.

Some behaviours can only be shown by the bench's scenarios. These are the fitness-driven choice of pair and its tie rule over a sequence of duels, the exact values left after intersection and removal, mask overwrite, and saturation at both ends of the fitness range.

// File: rtl/duel_iso_pkg.sv
package duel_iso_pkg;
  typedef enum logic {
    ART_ALWAYS    = 1'b0,
    ART_SOMETIMES = 1'b1
  } art_mode_e;
endpackage

// File: rtl/duel_iso_mask_store.sv
module duel_iso_mask_store #(
  parameter int NUM_RES = 16,
  parameter int NUM_CFG = 8,
  localparam int CFG_W = $clog2(NUM_CFG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [CFG_W-1:0]   waddr_i,
  input  logic [NUM_RES-1:0] wmask_i,
  input  logic [CFG_W-1:0]   left_i,
  input  logic [CFG_W-1:0]   right_i,
  output logic [NUM_RES-1:0] union_o
);
  logic [NUM_CFG-1:0][NUM_RES-1:0] mask_q;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[g] <= '0;
      else if (we_i && waddr_i == CFG_W'(g)) mask_q[g] <= wmask_i;
    end
  end

  assign union_o = mask_q[left_i] | mask_q[right_i];
endmodule

// File: rtl/duel_iso_pick.sv
module duel_iso_pick #(
  parameter int COUNT = 4,
  parameter int BASE  = 0,
  parameter int FIT_W = 8,
  parameter int CFG_W = 3
) (
  input  logic [COUNT-1:0][FIT_W-1:0] fit_i,
  output logic [CFG_W-1:0]            idx_o
);
  logic [FIT_W-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best  = fit_i[0];
    idx_o = CFG_W'(BASE);
    for (int i = 1; i < COUNT; i++) begin
      if (fit_i[i] > best) begin
        best  = fit_i[i];
        idx_o = CFG_W'(BASE + i);
      end
    end
  end
endmodule

// File: rtl/duel_iso_fitness.sv
module duel_iso_fitness #(
  parameter int NUM_CFG  = 8,
  parameter int FIT_W    = 8,
  parameter int FIT_INIT = 128,
  localparam int CFG_W = $clog2(NUM_CFG)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          upd_i,
  input  logic                          match_i,
  input  logic [CFG_W-1:0]              left_i,
  input  logic [CFG_W-1:0]              right_i,
  output logic [NUM_CFG-1:0][FIT_W-1:0] fit_o
);
  localparam logic [FIT_W-1:0] FIT_MAX = '1;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_fit
    logic hit;
    assign hit = upd_i && (left_i == CFG_W'(g) || right_i == CFG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fit_o[g] <= FIT_W'(FIT_INIT);
      end else if (hit) begin
        if (match_i) begin
          if (fit_o[g] != FIT_MAX) fit_o[g] <= fit_o[g] + 1'b1;
        end else begin
          if (fit_o[g] != '0) fit_o[g] <= fit_o[g] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/duel_iso_suspect.sv
module duel_iso_suspect
  import duel_iso_pkg::*;
#(
  parameter int NUM_RES = 16,
  localparam int RES_W = $clog2(NUM_RES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               match_i,
  input  logic               mode_i,
  input  logic [NUM_RES-1:0] pair_mask_i,
  output logic [NUM_RES-1:0] suspect_o,
  output logic               located_o,
  output logic [RES_W-1:0]   fault_idx_o,
  output logic               error_o
);
  logic [NUM_RES-1:0] cand;
  logic               seen_q;
  art_mode_e          mode;

  assign mode = art_mode_e'(mode_i);

  always_comb begin
    if (!match_i)                cand = suspect_o & pair_mask_i;
    else if (mode == ART_ALWAYS) cand = suspect_o & ~pair_mask_i;
    else                         cand = suspect_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      suspect_o <= '1;
      seen_q    <= 1'b0;
      error_o   <= 1'b0;
    end else if (upd_i) begin
      if (!match_i) seen_q <= 1'b1;
      if (cand == '0) error_o   <= 1'b1;
      else            suspect_o <= cand;
    end
  end

  // priority encoder, lowest set bit wins
  always_comb begin
    fault_idx_o = '0;
    for (int i = NUM_RES - 1; i >= 0; i--) begin
      if (suspect_o[i]) fault_idx_o = RES_W'(i);
    end
  end

  assign located_o = seen_q && ($countones(suspect_o) == 1);
endmodule

// File: rtl/duel_isolator.sv
module duel_isolator #(
  parameter int NUM_RES  = 16,
  parameter int NUM_CFG  = 8,
  parameter int FIT_W    = 8,
  parameter int FIT_INIT = 128,
  localparam int CFG_W = $clog2(NUM_CFG),
  localparam int RES_W = $clog2(NUM_RES),
  localparam int HALF  = NUM_CFG / 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [CFG_W-1:0]         cfg_waddr_i,
  input  logic [NUM_RES-1:0]       cfg_wmask_i,
  input  logic                     start_i,
  input  logic                     mode_i,
  input  logic                     res_valid_i,
  input  logic                     res_match_i,
  output logic                     pair_valid_o,
  output logic [CFG_W-1:0]         left_sel_o,
  output logic [CFG_W-1:0]         right_sel_o,
  output logic [NUM_RES-1:0]       suspect_o,
  output logic                     located_o,
  output logic [RES_W-1:0]         fault_idx_o,
  output logic                     error_o,
  output logic [NUM_CFG*FIT_W-1:0] fitness_o
);
  logic [NUM_CFG-1:0][FIT_W-1:0] fit;
  logic [CFG_W-1:0]              pick_l, pick_r;
  logic [NUM_RES-1:0]            pair_mask;
  logic                          upd;

  duel_iso_pick #(.COUNT(HALF), .BASE(0), .FIT_W(FIT_W), .CFG_W(CFG_W)) u_pick_l (
    .fit_i (fit[HALF-1:0]),
    .idx_o (pick_l)
  );

  duel_iso_pick #(.COUNT(HALF), .BASE(HALF), .FIT_W(FIT_W), .CFG_W(CFG_W)) u_pick_r (
    .fit_i (fit[NUM_CFG-1:HALF]),
    .idx_o (pick_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_valid_o <= 1'b0;
      left_sel_o   <= '0;
      right_sel_o  <= CFG_W'(HALF);
    end else if (!pair_valid_o) begin
      if (start_i) begin
        pair_valid_o <= 1'b1;
        left_sel_o   <= pick_l;
        right_sel_o  <= pick_r;
      end
    end else if (res_valid_i) begin
      pair_valid_o <= 1'b0;
    end
  end

  assign upd = pair_valid_o && res_valid_i;

  duel_iso_mask_store #(.NUM_RES(NUM_RES), .NUM_CFG(NUM_CFG)) u_masks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_waddr_i),
    .wmask_i (cfg_wmask_i),
    .left_i  (left_sel_o),
    .right_i (right_sel_o),
    .union_o (pair_mask)
  );

  duel_iso_fitness #(.NUM_CFG(NUM_CFG), .FIT_W(FIT_W), .FIT_INIT(FIT_INIT)) u_fit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .match_i (res_match_i),
    .left_i  (left_sel_o),
    .right_i (right_sel_o),
    .fit_o   (fit)
  );

  duel_iso_suspect #(.NUM_RES(NUM_RES)) u_susp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (upd),
    .match_i     (res_match_i),
    .mode_i      (mode_i),
    .pair_mask_i (pair_mask),
    .suspect_o   (suspect_o),
    .located_o   (located_o),
    .fault_idx_o (fault_idx_o),
    .error_o     (error_o)
  );

  assign fitness_o = fit;
endmodule

// File: rtl/duel_isolator_chk.sv
module duel_isolator_chk #(
  parameter int NUM_RES = 16,
  parameter int NUM_CFG = 8,
  parameter int FIT_W   = 8,
  localparam int CFG_W = $clog2(NUM_CFG),
  localparam int RES_W = $clog2(NUM_RES),
  localparam int HALF  = NUM_CFG / 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     mode_i,
  input logic                     res_valid_i,
  input logic                     res_match_i,
  input logic                     pair_valid_o,
  input logic [CFG_W-1:0]         left_sel_o,
  input logic [CFG_W-1:0]         right_sel_o,
  input logic [NUM_RES-1:0]       suspect_o,
  input logic                     located_o,
  input logic [RES_W-1:0]         fault_idx_o,
  input logic                     error_o,
  input logic [NUM_CFG*FIT_W-1:0] fitness_o
);
  assert_left_pool_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (int'(left_sel_o) < HALF));

  assert_right_pool_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (int'(right_sel_o) >= HALF));

  assert_pair_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && !res_valid_i) |=>
      (pair_valid_o && $stable(left_sel_o) && $stable(right_sel_o)));

  assert_duel_close_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && res_valid_i) |=> !pair_valid_o);

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_o |=> ($stable(suspect_o) && $stable(fitness_o)));

  assert_disc_narrows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && res_valid_i && !res_match_i) |=>
      ((suspect_o & ~$past(suspect_o)) == '0));

  assert_sometimes_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && res_valid_i && res_match_i && mode_i) |=> $stable(suspect_o));

  assert_error_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  assert_never_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspect_o != '0);

  assert_located_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    located_o |-> (($countones(suspect_o) == 1) && suspect_o[fault_idx_o]));
endmodule

bind duel_isolator duel_isolator_chk #(
  .NUM_RES (NUM_RES),
  .NUM_CFG (NUM_CFG),
  .FIT_W   (FIT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .res_valid_i  (res_valid_i),
  .res_match_i  (res_match_i),
  .pair_valid_o (pair_valid_o),
  .left_sel_o   (left_sel_o),
  .right_sel_o  (right_sel_o),
  .suspect_o    (suspect_o),
  .located_o    (located_o),
  .fault_idx_o  (fault_idx_o),
  .error_o      (error_o),
  .fitness_o    (fitness_o)
);

// File: tb/duel_isolator_test.sv
module duel_isolator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_RES = 16;
  localparam int NUM_CFG = 8;
  localparam int FIT_W   = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_waddr_i = '0;
  logic [15:0] cfg_wmask_i = '0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        res_valid_i = 1'b0;
  logic        res_match_i = 1'b0;
  logic        pair_valid_o;
  logic [2:0]  left_sel_o, right_sel_o;
  logic [15:0] suspect_o;
  logic        located_o;
  logic [3:0]  fault_idx_o;
  logic        error_o;
  logic [63:0] fitness_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duel_isolator uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_waddr_i(cfg_waddr_i),
    .cfg_wmask_i(cfg_wmask_i), .start_i(start_i), .mode_i(mode_i),
    .res_valid_i(res_valid_i), .res_match_i(res_match_i), .pair_valid_o(pair_valid_o),
    .left_sel_o(left_sel_o), .right_sel_o(right_sel_o), .suspect_o(suspect_o),
    .located_o(located_o), .fault_idx_o(fault_idx_o), .error_o(error_o),
    .fitness_o(fitness_o)
  );

  // {mode, match, exp_left, exp_right, exp_suspect, exp_located, exp_error}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd0, 3'd4, 16'h00FF, 1'b0, 1'b0},
    {1'b1, 1'b1, 3'd1, 3'd5, 16'h00FF, 1'b0, 1'b0},
    {1'b1, 1'b0, 3'd1, 3'd5, 16'h0042, 1'b0, 1'b0},
    {1'b0, 1'b0, 3'd1, 3'd5, 16'h0042, 1'b0, 1'b0},
    {1'b0, 1'b1, 3'd2, 3'd6, 16'h0040, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 3'd6, 16'h0040, 1'b1, 1'b1}
  };

  localparam logic [15:0] MASKS [8] = '{
    16'h000F, 16'h0042, 16'h0006, 16'h0100,
    16'h00F0, 16'h0C00, 16'h3000, 16'h0040
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fit_of(input int i);
    return fitness_o[i*FIT_W +: FIT_W];
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic write_mask(input int idx, input logic [15:0] m);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_waddr_i = 3'(idx); cfg_wmask_i = m;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic duel(input logic m, input logic mt, output logic [2:0] l, output logic [2:0] r);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    l = left_sel_o; r = right_sel_o;
    mode_i = m; res_match_i = mt; res_valid_i = 1'b1;
    @(negedge clk); res_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] l, r;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 suspect", 64'(suspect_o), 64'hFFFF);
    check("R1 pair_valid", 64'(pair_valid_o), 0);
    check("R1 located", 64'(located_o), 0);
    check("R1 error", 64'(error_o), 0);
    for (int i = 0; i < NUM_CFG; i++) check("R1 fitness", 64'(fit_of(i)), 128);

    for (int i = 0; i < NUM_CFG; i++) write_mask(i, MASKS[i]);

    // table walk: R3 selection, R5/R6/R7 suspect update, R8, R9
    for (int v = 0; v < 6; v++) begin
      duel(VEC[v][25], VEC[v][24], l, r);
      check("R3 left pick", 64'(l), 64'(VEC[v][23:21]));
      check("R3 right pick", 64'(r), 64'(VEC[v][20:18]));
      check("R4 duel closed", 64'(pair_valid_o), 0);
      check(VEC[v][24] ? (VEC[v][25] ? "R7 suspect" : "R6 suspect") : "R5 suspect",
            64'(suspect_o), 64'(VEC[v][17:2]));
      check("R9 located", 64'(located_o), 64'(VEC[v][1]));
      check("R8 error", 64'(error_o), 64'(VEC[v][0]));
      if (VEC[v][1]) check("R9 fault index", 64'(fault_idx_o), 6);
    end

    // R10 fitness after the table
    begin
      int exp_fit [8] = '{127, 127, 128, 128, 127, 127, 128, 128};
      for (int i = 0; i < NUM_CFG; i++) check("R10 fitness", 64'(fit_of(i)), 64'(exp_fit[i]));
    end

    // R4 result strobe while idle is ignored
    @(negedge clk); mode_i = 1'b0; res_match_i = 1'b0; res_valid_i = 1'b1;
    @(negedge clk); res_valid_i = 1'b0;
    @(negedge clk);
    check("R4 idle suspect", 64'(suspect_o), 64'h0040);
    check("R4 idle fitness", 64'(fit_of(2)), 128);
    check("R4 idle pair", 64'(pair_valid_o), 0);

    // R2 overwrite, R9 boundary index 0
    do_reset();
    write_mask(0, 16'h0010);
    write_mask(0, 16'h0001);
    duel(1'b0, 1'b0, l, r);
    check("R2 overwrite suspect", 64'(suspect_o), 64'h0001);
    check("R9 located idx0", 64'(located_o), 1);
    check("R9 fault index 0", 64'(fault_idx_o), 0);

    // R10 saturation up: zero masks keep suspect at all ones
    do_reset();
    for (int k = 0; k < 130; k++) duel(1'b0, 1'b1, l, r);
    check("R10 sat high left", 64'(fit_of(0)), 255);
    check("R10 sat high right", 64'(fit_of(4)), 255);
    check("R10 untouched", 64'(fit_of(1)), 128);
    check("R6 zero mask match", 64'(suspect_o), 64'hFFFF);
    check("R9 not located", 64'(located_o), 0);

    // R10 saturation down, R8 empty intersection keeps set
    for (int k = 0; k < 650; k++) duel(1'b1, 1'b0, l, r);
    for (int i = 0; i < NUM_CFG; i++) check("R10 sat low", 64'(fit_of(i)), 0);
    check("R8 error raised", 64'(error_o), 1);
    check("R8 suspect kept", 64'(suspect_o), 64'hFFFF);
    check("R9 many suspects", 64'(located_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule